// File: doc/BRIEF.md
# Multi-bank selectable clock divider

This block turns one source clock event stream into nine divided clock outputs arranged as four banks of one, one, two and five outputs. The whole block runs on a single core clock. The three candidate sources arrive as one-cycle tick strobes on that clock: a fast tick that stands for the internal high-rate oscillator, a crystal-derived reference tick and an external reference tick. A reference selector picks one of the two reference ticks. A bypass control then decides whether the dividers advance on the fast tick or on the chosen reference tick. Each output level changes only on a source tick, so the output period is a whole number of source ticks.

Each bank has a one-bit ratio select. The first bank divides by 2 or 4, and the other three banks divide by 4 or 8. Every output holds a 50% duty cycle. A shared frame counter spans eight source ticks, which is the longest period. Each bank picks up a new select value only when a frame ends, so every output rises in the same cycle as the slowest output. An active-low output enable drives a pad-drive flag that stands in for the output buffers' high-impedance control. A feedback-ratio select is decoded into the multiplier value, 32 or 16, reported to the modelled oscillator loop.

Each bank is a two-state machine. PH_HIGH is the first half-period, with the bank outputs at 1. PH_LOW is the second half-period, with the outputs at 0. On a source tick, the transition HIGH_TO_LOW fires when the half-period counter reaches its terminal count in PH_HIGH. LOW_TO_HIGH fires on the terminal count in PH_LOW, and this marks a full-period boundary. Reset places every bank in PH_HIGH.

Top module: `clkdiv_banks_top`

## Requirements
- R1: With `sel_a` = 0, `out_a` has a period of 2 source ticks; with `sel_a` = 1 the period is 4 source ticks.
- R2: Banks B, C and D have a period of 4 source ticks when their select is 0 and 8 source ticks when it is 1. All outputs within one bank are identical.
- R3: With `pll_en` = 1 the dividers advance on `vco_tick`. With `pll_en` = 0 they advance on the selected reference tick, and `vco_tick` has no effect.
- R4: With `ref_sel` = 0 the reference tick is `xtal_tick`; with `ref_sel` = 1 it is `ext_tick`. The unselected reference tick has no effect.
- R5: Every output is high for exactly half of its period, measured in core clock cycles.
- R6: Every rising edge of the output with the longest period coincides with a rising edge of all nine outputs.
- R7: A select is captured during synchronous reset. After that, a new value takes effect only at a frame end, which is the 8th, 16th, ... source tick after reset. Until then the bank keeps its old ratio.
- R8: While `rst` is high at a clock edge, all banks enter PH_HIGH, so every output is 1 in the cycle after that edge. The first source tick after reset is counted as tick 1 of the first frame.
- R9: `drive_en` is 1 when `oe_n` is 0 and 0 when `oe_n` is 1. This is the outputs' high-impedance control.
- R10: `fb_div` reads 32 when `fb_sel` = 0 and 16 when `fb_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| vco_tick | input | 1 | Fast internal source tick |
| xtal_tick | input | 1 | Crystal-derived reference tick |
| ext_tick | input | 1 | External reference tick |
| pll_en | input | 1 | 1: fast tick feeds dividers, 0: bypass to reference |
| ref_sel | input | 1 | 0: crystal tick, 1: external tick |
| oe_n | input | 1 | Active-low output enable |
| fb_sel | input | 1 | Feedback ratio select |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| sel_d | input | 1 | Bank D ratio select |
| out_a | output | 1 | Bank A clock |
| out_b | output | 1 | Bank B clock |
| out_c | output | C_N (2) | Bank C clocks |
| out_d | output | D_N (5) | Bank D clocks |
| drive_en | output | 1 | Pad drive flag; 0 means high impedance |
| fb_div | output | FB_W (6) | Feedback multiplier value |

## Verification
The bench measures the period and high time of every output for six source and select combinations. It sets the cadences of the fast, crystal and external ticks to 1, 3 and 5 core cycles. A wrong mux choice therefore shows up as a period scaled by the wrong cadence, and a swapped ratio shows up as a period off by a factor of two. One directed test changes bank A's select in the middle of a frame and follows the output cycle by cycle. A design that applied the select at once, or at the bank's own period boundary, would break the expected sequence before the eighth tick. The bench also checks that no output rises out of step with the slowest output, that the reset state has every output high, and that the enable flag and the feedback decode give the right values.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    function automatic logic [5:0] fb_ratio(input logic fsel);
        return fsel ? 6'd16 : 6'd32;
    endfunction

endpackage

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux (
    input  logic vco_tick,
    input  logic xtal_tick,
    input  logic ext_tick,
    input  logic pll_en,
    input  logic ref_sel,
    output logic src_tick
);
    logic ref_tick;

    always_comb begin
        ref_tick = ref_sel ? ext_tick : xtal_tick;
        src_tick = pll_en ? vco_tick : ref_tick;
    end
endmodule

// File: rtl/clkdiv_frame.sv
module clkdiv_frame #(
    parameter int FRAME = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic frame_end
);
    localparam int FW = (FRAME > 2) ? $clog2(FRAME) : 1;
    localparam logic [FW-1:0] LAST = FW'(FRAME - 1);

    logic [FW-1:0] fcnt;

    always_ff @(posedge clk) begin
        if (rst)
            fcnt <= '0;
        else if (tick)
            fcnt <= (fcnt == LAST) ? '0 : fcnt + 1'b1;
    end

    always_comb frame_end = tick && (fcnt == LAST);
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 8,
    parameter int N_OUT  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             frame_end,
    input  logic             sel,
    output logic [N_OUT-1:0] q
);
    localparam int CW = $clog2(DIV_HI);
    localparam logic [CW-1:0] LAST_LO = CW'(DIV_LO / 2 - 1);
    localparam logic [CW-1:0] LAST_HI = CW'(DIV_HI / 2 - 1);

    phase_e        state, nstate;
    logic [CW-1:0] cnt;
    logic          sel_q;
    logic          term;
    logic          level;

    always_comb term = (cnt == (sel_q ? LAST_HI : LAST_LO));

    // State register, half-period counter and captured select
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_HIGH;
            cnt   <= '0;
            sel_q <= sel;
        end else if (tick) begin
            state <= nstate;
            cnt   <= term ? '0 : cnt + 1'b1;
            if (frame_end)
                sel_q <= sel;
        end
    end

    // Transitions: HIGH_TO_LOW and LOW_TO_HIGH on terminal count
    always_comb begin
        nstate = state;
        if (term) begin
            unique case (state)
                PH_HIGH: nstate = PH_LOW;
                PH_LOW:  nstate = PH_HIGH;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            PH_HIGH: level = 1'b1;
            PH_LOW:  level = 1'b0;
        endcase
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_fan
        assign q[i] = level;
    end
endmodule

// File: rtl/clkdiv_banks_top.sv
module clkdiv_banks_top
    import clkdiv_pkg::*;
#(
    parameter int C_N    = 2,
    parameter int D_N    = 5,
    parameter int A_LO   = 2,
    parameter int A_HI   = 4,
    parameter int BCD_LO = 4,
    parameter int BCD_HI = 8,
    parameter int FB_W   = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vco_tick,
    input  logic            xtal_tick,
    input  logic            ext_tick,
    input  logic            pll_en,
    input  logic            ref_sel,
    input  logic            oe_n,
    input  logic            fb_sel,
    input  logic            sel_a,
    input  logic            sel_b,
    input  logic            sel_c,
    input  logic            sel_d,
    output logic            out_a,
    output logic            out_b,
    output logic [C_N-1:0]  out_c,
    output logic [D_N-1:0]  out_d,
    output logic            drive_en,
    output logic [FB_W-1:0] fb_div
);
    localparam int FRAME = (A_HI > BCD_HI) ? A_HI : BCD_HI;

    logic src_tick;
    logic frame_end;

    clkdiv_src_mux u_mux (
        .vco_tick (vco_tick),
        .xtal_tick(xtal_tick),
        .ext_tick (ext_tick),
        .pll_en   (pll_en),
        .ref_sel  (ref_sel),
        .src_tick (src_tick)
    );

    clkdiv_frame #(.FRAME(FRAME)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .tick     (src_tick),
        .frame_end(frame_end)
    );

    clkdiv_bank #(.DIV_LO(A_LO), .DIV_HI(A_HI), .N_OUT(1)) u_bank_a (
        .clk(clk), .rst(rst), .tick(src_tick), .frame_end(frame_end),
        .sel(sel_a), .q(out_a)
    );

    clkdiv_bank #(.DIV_LO(BCD_LO), .DIV_HI(BCD_HI), .N_OUT(1)) u_bank_b (
        .clk(clk), .rst(rst), .tick(src_tick), .frame_end(frame_end),
        .sel(sel_b), .q(out_b)
    );

    clkdiv_bank #(.DIV_LO(BCD_LO), .DIV_HI(BCD_HI), .N_OUT(C_N)) u_bank_c (
        .clk(clk), .rst(rst), .tick(src_tick), .frame_end(frame_end),
        .sel(sel_c), .q(out_c)
    );

    clkdiv_bank #(.DIV_LO(BCD_LO), .DIV_HI(BCD_HI), .N_OUT(D_N)) u_bank_d (
        .clk(clk), .rst(rst), .tick(src_tick), .frame_end(frame_end),
        .sel(sel_d), .q(out_d)
    );

    always_comb begin
        drive_en = ~oe_n;
        fb_div   = FB_W'(fb_ratio(fb_sel));
    end
endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk #(
    parameter int C_N  = 2,
    parameter int D_N  = 5,
    parameter int FB_W = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            src_tick,
    input logic            frame_end,
    input logic            out_a,
    input logic            out_b,
    input logic [C_N-1:0]  out_c,
    input logic [D_N-1:0]  out_d,
    input logic [FB_W-1:0] fb_div
);
    localparam int NQ = 2 + C_N + D_N;

    logic [NQ-1:0] all_q;
    assign all_q = {out_a, out_b, out_c, out_d};

    // R10: multiplier value is always one of the two legal ratios
    assert_fb_legal_R10: assert property (@(posedge clk) disable iff (rst)
        (fb_div == FB_W'(16)) || (fb_div == FB_W'(32)));

    // R2: outputs in one bank never differ
    assert_bank_copies_R2: assert property (@(posedge clk) disable iff (rst)
        (out_c == {C_N{out_c[0]}}) && (out_d == {D_N{out_d[0]}}));

    // R3: no output moves without a selected source tick
    assert_tick_gated_R3: assert property (@(posedge clk) disable iff (rst)
        !src_tick |=> $stable(all_q));

    // R6 / R7: a frame end puts every output high together
    assert_frame_align_R6: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (&all_q));

    // R8: first cycle out of reset has every output high
    assert_reset_high_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&all_q));
endmodule

bind clkdiv_banks_top clkdiv_banks_chk #(.C_N(C_N), .D_N(D_N), .FB_W(FB_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_tick (src_tick),
    .frame_end(frame_end),
    .out_a    (out_a),
    .out_b    (out_b),
    .out_c    (out_c),
    .out_d    (out_d),
    .fb_div   (fb_div)
);

// File: tb/clkdiv_banks_top_test.sv
module clkdiv_banks_top_test;
    localparam int W        = 240;
    localparam int NVEC     = 6;
    localparam int WATCHDOG = 100000;

    // {pll_en, ref_sel, sel_a, sel_b, sel_c, sel_d, per_a, per_b, per_c, per_d}
    // periods in core cycles; tick cadences: fast 1, crystal 3, external 5
    localparam logic [37:0] VECS [NVEC] = '{
        {1'b1, 1'b0, 4'b0000, 8'd2,  8'd4,  8'd4,  8'd4 },
        {1'b1, 1'b0, 4'b1111, 8'd4,  8'd8,  8'd8,  8'd8 },
        {1'b0, 1'b0, 4'b0101, 8'd6,  8'd24, 8'd12, 8'd24},
        {1'b0, 1'b1, 4'b1010, 8'd20, 8'd20, 8'd40, 8'd20},
        {1'b1, 1'b1, 4'b0011, 8'd2,  8'd4,  8'd8,  8'd8 },
        {1'b0, 1'b1, 4'b0000, 8'd10, 8'd20, 8'd20, 8'd20}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vco_tick = 1'b1;
    logic xtal_tick = 1'b0;
    logic ext_tick = 1'b0;
    logic pll_en = 1'b1, ref_sel = 1'b0, oe_n = 1'b0, fb_sel = 1'b0;
    logic sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0, sel_d = 1'b0;
    logic       out_a, out_b, drive_en;
    logic [1:0] out_c;
    logic [4:0] out_d;
    logic [5:0] fb_div;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [8:0] hist [W];

    clkdiv_banks_top uut (
        .clk(clk), .rst(rst), .vco_tick(vco_tick), .xtal_tick(xtal_tick),
        .ext_tick(ext_tick), .pll_en(pll_en), .ref_sel(ref_sel), .oe_n(oe_n),
        .fb_sel(fb_sel), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .sel_d(sel_d), .out_a(out_a), .out_b(out_b), .out_c(out_c),
        .out_d(out_d), .drive_en(drive_en), .fb_div(fb_div)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        cyc       = cyc + 1;
        xtal_tick = (cyc % 3 == 0);
        ext_tick  = (cyc % 5 == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] all_out();
        return {out_a, out_b, out_c, out_d};
    endfunction

    task automatic start(input logic p, input logic r, input logic [3:0] s);
        @(negedge clk);
        pll_en = p; ref_sel = r;
        {sel_a, sel_b, sel_c, sel_d} = s;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic string req_of(input int j);
        return (j == 8) ? "R1" : "R2";
    endfunction

    task automatic run_vec(input logic [37:0] v);
        int per [9];
        int slow;
        int bad;
        per[8] = int'(v[31:24]);
        per[7] = int'(v[23:16]);
        per[6] = int'(v[15:8]); per[5] = per[6];
        for (int j = 0; j < 5; j++) per[j] = int'(v[7:0]);
        start(v[37], v[36], v[35:32]);
        repeat (20) @(negedge clk);
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            hist[k] = all_out();
        end
        slow = 0;
        for (int j = 0; j < 9; j++)
            if (per[j] > per[slow]) slow = j;
        for (int j = 0; j < 9; j++) begin
            int first = -1, last = -1, prev = -1, highs = 0;
            for (int k = 1; k < W; k++)
                if (hist[k][j] && !hist[k-1][j]) begin
                    if (first < 0) first = k;
                    prev = last;
                    last = k;
                end
            // R3 / R4 set the cadence, R1 / R2 the ratio
            check(prev >= 0 && (last - prev) == per[j],
                  {req_of(j), " R3 R4 period"}, last - prev, per[j]);
            for (int k = (first < 0 ? 0 : first); k < last; k++)
                if (hist[k][j]) highs++;
            check(2 * highs == (last - first), "R5 duty", 2 * highs, last - first);
        end
        bad = 0;
        for (int k = 1; k < W; k++)
            if (hist[k][slow] && !hist[k-1][slow])
                if (hist[k] != 9'h1FF || hist[k-1] != 9'h000) bad++;
        check(bad == 0, "R6 alignment", bad, 0);
    endtask

    initial begin
        #(WATCHDOG * 4);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [8:0] seq_a;
        // reset state, R8
        repeat (3) @(negedge clk);
        check(all_out() == 9'h1FF, "R8 reset level", int'(all_out()), 9'h1FF);

        // enable flag, R9
        oe_n = 1'b1; #1;
        check(drive_en == 1'b0, "R9 disabled", drive_en, 0);
        oe_n = 1'b0; #1;
        check(drive_en == 1'b1, "R9 enabled", drive_en, 1);

        // feedback decode, R10
        fb_sel = 1'b0; #1;
        check(fb_div == 6'd32, "R10 fb 0", fb_div, 32);
        fb_sel = 1'b1; #1;
        check(fb_div == 6'd16, "R10 fb 1", fb_div, 16);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R7: mid-frame select change on bank A, fast tick every cycle
        start(1'b1, 1'b0, 4'b0000);
        check(all_out() == 9'h1FF, "R8 after release", int'(all_out()), 9'h1FF);
        repeat (3) @(negedge clk);
        sel_a = 1'b1;
        seq_a = 9'b101011001; // after ticks 4..12, MSB first
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            check(out_a == seq_a[8-k], "R7 boundary", out_a, seq_a[8-k]);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule